// File: doc/BRIEF.md
# Serial Flash Host Sequencer

This block is the host side of a small serial flash that has no shared serial clock. Instead it uses four single-purpose pins: a mode-select level, a control strobe, an address shift clock and a data clock, plus one bidirectional data line and an end-of-process flag that comes back from the flash. Software places an operation code, a mode-select pulse count, a start address and, for writes, a 32-bit frame on the command inputs, then pulses `start`. The sequencer then raises the mode-select pin and counts the requested strobes on the control pin while it is high. It shifts the address in, moves a 32-bit frame in either direction, and for program or erase operations fires one control pulse and waits for the flash to report completion.

All timing comes from a single parameter, the system clock rate in MHz. From it the block derives the half period of every pin clock, which gives a pin rate of at most 1 MHz with an even duty cycle. It also derives the 500 ns mode-select margins, the 1 µs gaps between phases, the program pulse width and the completion timeout. One down-counting timer measures every interval, so any legal clock rate needs no further tuning. If the flash never raises its completion flag, the command still ends, and the block reports an error.

Top module: `sflash_seq`

## Requirements
- R1: While reset is held, and at any time the block is idle, `busy`, `done`, `fl_mode`, `fl_ctrl`, `fl_aclk`, `fl_dclk` and `fl_data_oe` are all low.
- R2: A command raises `fl_mode`. At least the mode margin (half a microsecond) later, exactly `npul` pulses appear on `fl_ctrl`, each one half period high after one half period low. `fl_mode` then stays high for at least the mode margin after the last pulse falls. With `npul` = 0 no pulse appears.
- R3: After `fl_mode` falls, no rising edge appears on `fl_aclk`, `fl_dclk` or `fl_ctrl` for at least one gap (1 µs). The mode-select pin is never high while a data or address clock is high.
- R4: For operation codes 0, 1 and 2, the address is sent most significant bit first, `ADDR_W` bits, one bit per `fl_aclk` pulse. `fl_data_oe` is high, and `fl_data_o` is stable for the whole high phase of each `fl_aclk` pulse.
- R5: At least one gap separates the last falling edge of `fl_aclk` from the first rising edge of `fl_dclk` (codes 0 and 1), or from the erase pulse (code 2).
- R6: Operation code 1 (write) sends the 32-bit frame most significant bit first, with one bit on each `fl_dclk` rise, while the data line is driven. The program pulse on `fl_ctrl` starts at least one gap after the last `fl_dclk` fall.
- R7: Operation code 0 (read) releases the data line (`fl_data_oe` low). It samples `fl_data_i` at the end of each of 32 `fl_dclk` high phases, with the first sample as the most significant bit. The result is presented on `rframe` when `done` pulses, and no control pulse is issued.
- R8: Codes 1, 2 and 3 issue one `fl_ctrl` pulse with `fl_mode` low, lasting exactly `CLK_MHZ*PULSE_US` cycles. After it the block waits for `fl_eop` high, then ends the command with `done` and `err` low.
- R9: If `fl_eop` is not high within `CLK_MHZ*EOP_TO_US` cycles after the pulse ends, the command ends with `done` and `err` high. `err` stays high until the next accepted `start` clears it.
- R10: Operation code 3 (whole-array erase) sends no address bits and no data clocks. Its pulse follows the mode gap directly.
- R11: `busy` is high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle, with `busy` low. A `start` while busy is ignored and does not change the running command or its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously upstream |
| start | input | 1 | Accept a command when idle |
| op | input | 2 | Operation code: 0 read, 1 write, 2 block erase, 3 whole-array erase |
| npul | input | NPUL_W | Number of control strobes during mode selection |
| addr | input | ADDR_W | Start address |
| wframe | input | 32 | Frame to write |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion flag timed out on the last command |
| rframe | output | 32 | Frame read by the last read command |
| fl_mode | output | 1 | Mode-select pin |
| fl_ctrl | output | 1 | Control strobe pin |
| fl_aclk | output | 1 | Address shift clock pin |
| fl_dclk | output | 1 | Data clock pin |
| fl_data_o | output | 1 | Data line output value |
| fl_data_oe | output | 1 | Data line output enable |
| fl_data_i | input | 1 | Data line input value |
| fl_eop | input | 1 | End-of-process flag from the flash |

## Verification
The bench builds the block with `CLK_MHZ` = 4, `PULSE_US` = 4, `EOP_TO_US` = 10, `ADDR_W` = 8 and `NPUL_W` = 3. With these values a half period and the mode margin are 2 cycles, a gap is 4 cycles, the program pulse is 16 cycles and the completion timeout is 40 cycles. The timeout path and the widest mode-select count of 7 are then only a few hundred cycles away. Every operation code is run against a bench model of the flash that measures gaps, pulse widths and shifted bits at the pins. The bench also fires a second `start` in the middle of a write.

// File: rtl/sflash_pkg.sv
`timescale 1ns/1ps
package sflash_pkg;
  localparam int FRAME_W = 32;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_BERASE = 2'd2,
    OP_CERASE = 2'd3
  } sf_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MSU, ST_MPUL, ST_MHLD, ST_MGAP, ST_ASH, ST_AGAP,
    ST_DRD, ST_DWR, ST_WGAP, ST_PULSE, ST_EOP
  } sf_st_e;
endpackage

// File: rtl/sflash_tmr.sv
`timescale 1ns/1ps
// Down counter shared by every phase: load N-1 to spend N cycles.
module sflash_tmr #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = val;
    else if (cnt_q != '0) cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sflash_shreg.sv
`timescale 1ns/1ps
// Left shift register: MSB is the next bit out, sin enters at bit 0.
module sflash_shreg #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load)       q_d = din;
    else if (shift) q_d = {q[W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/sflash_seq.sv
`timescale 1ns/1ps
module sflash_seq
  import sflash_pkg::*;
#(
  parameter int CLK_MHZ   = 200,
  parameter int PULSE_US  = 400,
  parameter int EOP_TO_US = 100000,
  parameter int ADDR_W    = 16,
  parameter int NPUL_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          op,
  input  logic [NPUL_W-1:0]   npul,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [FRAME_W-1:0]  wframe,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [FRAME_W-1:0]  rframe,
  output logic                fl_mode,
  output logic                fl_ctrl,
  output logic                fl_aclk,
  output logic                fl_dclk,
  output logic                fl_data_o,
  output logic                fl_data_oe,
  input  logic                fl_data_i,
  input  logic                fl_eop
);
  // Derived timing, all in system-clock cycles.
  localparam int HALF_C  = (CLK_MHZ + 1) / 2;
  localparam int MSU_C   = (CLK_MHZ + 1) / 2;
  localparam int GAP_C   = CLK_MHZ;
  localparam int PULSE_C = CLK_MHZ * PULSE_US;
  localparam int TO_C    = CLK_MHZ * EOP_TO_US;
  localparam int TMAX    = (TO_C > PULSE_C) ? TO_C : PULSE_C;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int BMAX    = (ADDR_W > FRAME_W) ? ADDR_W : FRAME_W;
  localparam int BMAX2   = (BMAX > (1 << NPUL_W)) ? BMAX : (1 << NPUL_W);
  localparam int BW      = $clog2(BMAX2 + 1);
  localparam int SH_W    = ADDR_W + FRAME_W;

  localparam logic [TW-1:0] LD_HALF  = TW'(HALF_C - 1);
  localparam logic [TW-1:0] LD_MSU   = TW'(MSU_C - 1);
  localparam logic [TW-1:0] LD_GAP   = TW'(GAP_C - 1);
  localparam logic [TW-1:0] LD_PULSE = TW'(PULSE_C - 1);
  localparam logic [TW-1:0] LD_TO    = TW'(TO_C - 1);
  localparam logic [BW-1:0] A_LAST   = BW'(ADDR_W - 1);
  localparam logic [BW-1:0] F_LAST   = BW'(FRAME_W - 1);

  sf_st_e              state_q, state_d;
  sf_op_e              op_q, op_d;
  logic [NPUL_W-1:0]   npul_q, npul_d;
  logic [BW-1:0]       bit_q, bit_d, last_bit;
  logic                ph_q, ph_d;
  logic                err_d, done_d;
  logic                t_ld, tz;
  logic [TW-1:0]       t_val;
  logic                s_ld, s_sh;
  logic [SH_W-1:0]     sh_q;

  sflash_tmr #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_ld), .val(t_val), .zero(tz)
  );

  // Address then frame leave from the MSB; read bits enter at bit 0.
  sflash_shreg #(.W(SH_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(s_ld), .din({addr, wframe}),
    .shift(s_sh), .sin(fl_data_i), .q(sh_q)
  );

  always_comb begin
    case (state_q)
      ST_MPUL: last_bit = BW'(npul_q) - BW'(1);
      ST_ASH:  last_bit = A_LAST;
      default: last_bit = F_LAST;
    endcase
  end

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    npul_d  = npul_q;
    bit_d   = bit_q;
    ph_d    = ph_q;
    err_d   = err;
    done_d  = 1'b0;
    t_ld    = 1'b0;
    t_val   = LD_HALF;
    s_ld    = 1'b0;
    s_sh    = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_MSU;
        op_d    = sf_op_e'(op);
        npul_d  = npul;
        err_d   = 1'b0;
        s_ld    = 1'b1;
        t_ld    = 1'b1;
        t_val   = LD_MSU;
      end
      ST_MSU: if (tz) begin
        t_ld  = 1'b1;
        ph_d  = 1'b0;
        bit_d = '0;
        if (npul_q == '0) begin state_d = ST_MHLD; t_val = LD_MSU; end
        else                    state_d = ST_MPUL;
      end
      ST_MPUL, ST_ASH, ST_DRD, ST_DWR: if (tz) begin
        t_ld = 1'b1;
        ph_d = ~ph_q;
        if (ph_q) begin
          bit_d = bit_q + BW'(1);
          s_sh  = (state_q != ST_MPUL);
          if (bit_q == last_bit) begin
            case (state_q)
              ST_MPUL: begin state_d = ST_MHLD; t_val = LD_MSU; end
              ST_ASH:  begin state_d = ST_AGAP; t_val = LD_GAP; end
              ST_DWR:  begin state_d = ST_WGAP; t_val = LD_GAP; end
              default: begin state_d = ST_IDLE; t_ld = 1'b0; done_d = 1'b1; end
            endcase
          end
        end
      end
      ST_MHLD: if (tz) begin state_d = ST_MGAP; t_ld = 1'b1; t_val = LD_GAP; end
      ST_MGAP: if (tz) begin
        t_ld  = 1'b1;
        ph_d  = 1'b0;
        bit_d = '0;
        if (op_q == OP_CERASE) begin state_d = ST_PULSE; t_val = LD_PULSE; end
        else                         state_d = ST_ASH;
      end
      ST_AGAP: if (tz) begin
        t_ld  = 1'b1;
        ph_d  = 1'b0;
        bit_d = '0;
        case (op_q)
          OP_READ:  state_d = ST_DRD;
          OP_WRITE: state_d = ST_DWR;
          default:  begin state_d = ST_PULSE; t_val = LD_PULSE; end
        endcase
      end
      ST_WGAP:  if (tz) begin state_d = ST_PULSE; t_ld = 1'b1; t_val = LD_PULSE; end
      ST_PULSE: if (tz) begin state_d = ST_EOP;   t_ld = 1'b1; t_val = LD_TO; end
      ST_EOP: begin
        if (fl_eop) begin
          state_d = ST_IDLE; done_d = 1'b1;
        end else if (tz) begin
          state_d = ST_IDLE; done_d = 1'b1; err_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_READ;
      npul_q  <= '0;
      bit_q   <= '0;
      ph_q    <= 1'b0;
      err     <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      npul_q  <= npul_d;
      bit_q   <= bit_d;
      ph_q    <= ph_d;
      err     <= err_d;
      done    <= done_d;
    end
  end

  // Pin clocks come straight from flops, decoded from the next state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_mode    <= 1'b0;
      fl_ctrl    <= 1'b0;
      fl_aclk    <= 1'b0;
      fl_dclk    <= 1'b0;
      fl_data_oe <= 1'b0;
    end else begin
      fl_mode    <= (state_d == ST_MSU) || (state_d == ST_MPUL) || (state_d == ST_MHLD);
      fl_ctrl    <= ((state_d == ST_MPUL) && ph_d) || (state_d == ST_PULSE);
      fl_aclk    <= (state_d == ST_ASH) && ph_d;
      fl_dclk    <= ((state_d == ST_DRD) || (state_d == ST_DWR)) && ph_d;
      fl_data_oe <= (state_d == ST_ASH) || (state_d == ST_DWR);
    end
  end

  assign fl_data_o = ((state_q == ST_ASH) || (state_q == ST_DWR)) ? sh_q[SH_W-1] : 1'b0;
  assign rframe    = sh_q[FRAME_W-1:0];
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/sflash_seq_chk.sv
`timescale 1ns/1ps
module sflash_seq_chk #(
  parameter int CLK_MHZ  = 200,
  parameter int PULSE_US = 400
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic fl_mode,
  input logic fl_ctrl,
  input logic fl_aclk,
  input logic fl_dclk,
  input logic fl_data_o,
  input logic fl_data_oe
);
  localparam int MSU_C   = (CLK_MHZ + 1) / 2;
  localparam int GAP_C   = CLK_MHZ;
  localparam int PULSE_C = CLK_MHZ * PULSE_US;
  localparam int CW      = $clog2(PULSE_C + GAP_C + 2);

  logic [CW-1:0] mhi_cnt, mlo_cnt, pw_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mhi_cnt <= '0;
      mlo_cnt <= CW'(GAP_C);
      pw_cnt  <= '0;
    end else begin
      if (!fl_mode)                   mhi_cnt <= '0;
      else if (mhi_cnt < CW'(MSU_C))  mhi_cnt <= mhi_cnt + CW'(1);
      if (fl_mode)                    mlo_cnt <= '0;
      else if (mlo_cnt < CW'(GAP_C))  mlo_cnt <= mlo_cnt + CW'(1);
      if (!fl_ctrl)                   pw_cnt <= '0;
      else if (!fl_mode)              pw_cnt <= pw_cnt + CW'(1);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(fl_mode || fl_ctrl || fl_aclk || fl_dclk || fl_data_oe)); // R1
  AST_MSEL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_ctrl) && fl_mode) |-> (mhi_cnt >= CW'(MSU_C))); // R2
  AST_MODE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_aclk) || $rose(fl_dclk) || ($rose(fl_ctrl) && !fl_mode)) |-> (mlo_cnt >= CW'(GAP_C))); // R3
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_mode && (fl_aclk || fl_dclk)) && $onehot0({fl_aclk, fl_dclk, fl_ctrl})); // R3
  AST_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    fl_aclk |-> fl_data_oe); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_aclk && $past(fl_aclk)) |-> $stable(fl_data_o)); // R4
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_dclk && $past(fl_dclk) && fl_data_oe) |-> $stable(fl_data_o)); // R6
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_ctrl) && !fl_mode) |-> (pw_cnt == CW'(PULSE_C))); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
endmodule

bind sflash_seq sflash_seq_chk #(.CLK_MHZ(CLK_MHZ), .PULSE_US(PULSE_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fl_mode(fl_mode),
  .fl_ctrl(fl_ctrl), .fl_aclk(fl_aclk), .fl_dclk(fl_dclk),
  .fl_data_o(fl_data_o), .fl_data_oe(fl_data_oe)
);

// File: tb/sim_sflash_seq.sv
`timescale 1ns/1ps
module sim_sflash_seq;
  localparam int CLK_MHZ = 4, PULSE_US = 4, EOP_TO_US = 10, ADDR_W = 8, NPUL_W = 3;
  localparam int MSU = 2, GAP = 4, PULSE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [NPUL_W-1:0] npul_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0] wframe_i = '0;
  logic busy, done, err, fl_mode, fl_ctrl, fl_aclk, fl_dclk, fl_data_o, fl_data_oe;
  logic [31:0] rframe;
  logic fl_data_i = 1'b0;
  logic fl_eop = 1'b0;

  sflash_seq #(.CLK_MHZ(CLK_MHZ), .PULSE_US(PULSE_US), .EOP_TO_US(EOP_TO_US),
               .ADDR_W(ADDR_W), .NPUL_W(NPUL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .npul(npul_i),
    .addr(addr_i), .wframe(wframe_i), .busy(busy), .done(done), .err(err),
    .rframe(rframe), .fl_mode(fl_mode), .fl_ctrl(fl_ctrl), .fl_aclk(fl_aclk),
    .fl_dclk(fl_dclk), .fl_data_o(fl_data_o), .fl_data_oe(fl_data_oe),
    .fl_data_i(fl_data_i), .fl_eop(fl_eop)
  );

  typedef struct {
    logic [1:0] op; int npul; logic [ADDR_W-1:0] addr;
    logic [31:0] wf; logic [31:0] rf; logic err; int pw;
  } exp_t;
  exp_t sbq[$];

  int checks = 0, errors = 0, cyc = 0, done_cnt = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Flash model and scoreboard monitor, sampled away from the clock edge.
  logic [31:0] rd_word = '0;
  bit eop_en = 1'b0;
  logic p_mode = 0, p_ctrl = 0, p_aclk = 0, p_dclk = 0;
  int obs_npul = 0, obs_abits = 0, obs_dbits = 0, obs_pw = 0, gap_bad = 0;
  int t_mrise = 0, t_cfall = 0, t_fall = 0, t_crise = 0, last_kind = 3, rbit = 0, eop_cnt = -1;
  logic [ADDR_W-1:0] obs_addr = '0;
  logic [31:0] obs_wf = '0;

  always @(negedge clk) begin
    if (fl_mode && !p_mode) begin
      obs_npul = 0; obs_abits = 0; obs_dbits = 0; obs_pw = 0; gap_bad = 0;
      obs_addr = '0; obs_wf = '0; rbit = 0; t_mrise = cyc; last_kind = 3;
    end
    if (fl_ctrl && !p_ctrl) begin
      if (fl_mode) begin
        obs_npul++;
        if (obs_npul == 1 && cyc - t_mrise < MSU) gap_bad++;
      end else begin
        t_crise = cyc;
        if (cyc - t_fall < GAP) gap_bad++;
      end
    end
    if (!fl_ctrl && p_ctrl) begin
      if (fl_mode) t_cfall = cyc;
      else begin obs_pw = cyc - t_crise; eop_cnt = eop_en ? 6 : -1; end
    end
    if (!fl_mode && p_mode) begin
      if (obs_npul > 0 && cyc - t_cfall < MSU) gap_bad++;
      t_fall = cyc; last_kind = 0;
    end
    if (fl_aclk && !p_aclk) begin
      if (last_kind != 1 && cyc - t_fall < GAP) gap_bad++;
      if (!fl_data_oe) gap_bad++;
      obs_addr = {obs_addr[ADDR_W-2:0], fl_data_o}; obs_abits++;
    end
    if (!fl_aclk && p_aclk) begin t_fall = cyc; last_kind = 1; end
    if (fl_dclk && !p_dclk) begin
      if (last_kind != 2 && cyc - t_fall < GAP) gap_bad++;
      obs_dbits++;
      if (fl_data_oe) obs_wf = {obs_wf[30:0], fl_data_o};
      else begin fl_data_i = rd_word[31 - rbit]; rbit++; end
    end
    if (!fl_dclk && p_dclk) begin t_fall = cyc; last_kind = 2; end
    if (eop_cnt > 0) eop_cnt--;
    else if (eop_cnt == 0) begin fl_eop = 1'b1; eop_cnt = -1; end
    p_mode = fl_mode; p_ctrl = fl_ctrl; p_aclk = fl_aclk; p_dclk = fl_dclk;

    if (done) begin
      exp_t e;
      done_cnt++;
      fl_eop = 1'b0;
      if (sbq.size() == 0) chk("R11 done without command", 1, 0);
      else begin
        e = sbq.pop_front();
        chk("R11 busy low at done", busy, 0);
        chk("R2 mode strobe count", obs_npul, e.npul);
        chk("R3 R5 R6 gap and margin violations", gap_bad, 0);
        chk("R8 R9 err flag", err, e.err);
        chk("R8 pulse width", obs_pw, e.pw);
        if (e.op == 2'd3) chk("R10 no address or data clocks", obs_abits + obs_dbits, 0);
        else begin
          chk("R4 address bit count", obs_abits, ADDR_W);
          chk("R4 address value", obs_addr, e.addr);
        end
        if (e.op == 2'd0) chk("R7 read frame", rframe, e.rf);
        if (e.op == 2'd1) chk("R6 write frame", obs_wf, e.wf);
        if (e.op[1]) chk("R10 R8 erase without data clocks", obs_dbits, 0);
        else         chk("R6 R7 data clock count", obs_dbits, 32);
      end
    end
  end

  // Driver: pushes the expectation, then launches the command.
  task automatic issue(input logic [1:0] o, input int np, input logic [ADDR_W-1:0] a,
                       input logic [31:0] w, input logic [31:0] r, input bit eopok, input bit poke);
    exp_t e;
    int n;
    @(negedge clk);
    op_i = o; npul_i = NPUL_W'(np); addr_i = a; wframe_i = w; rd_word = r; eop_en = eopok;
    e.op = o; e.npul = np; e.addr = a; e.wf = w; e.rf = r;
    e.err = (o != 2'd0) && !eopok;
    e.pw = (o == 2'd0) ? 0 : PULSE;
    sbq.push_back(e);
    n = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 busy after start", busy, 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      op_i = 2'd3; npul_i = 1; addr_i = '1; wframe_i = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == n) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R11 stays idle after done", busy, 0);
    chk("R1 pins quiet while idle", {fl_mode, fl_ctrl, fl_aclk, fl_dclk, fl_data_oe}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", {busy, done, err, fl_mode, fl_ctrl, fl_aclk, fl_dclk, fl_data_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {busy, done, err, fl_mode, fl_ctrl, fl_aclk, fl_dclk, fl_data_oe}, 0);
    issue(2'd0, 2, 8'hA5, 32'h0, 32'hDEADBEEF, 1'b1, 1'b0); // R7 read
    issue(2'd1, 3, 8'h3C, 32'h12345678, 32'h0, 1'b1, 1'b0); // R6 write
    issue(2'd2, 1, 8'h81, 32'h0, 32'h0, 1'b1, 1'b0);        // R5 block erase
    issue(2'd3, 7, 8'h00, 32'h0, 32'h0, 1'b1, 1'b0);        // R10 whole-array erase
    issue(2'd0, 0, 8'h00, 32'h0, 32'h80000001, 1'b1, 1'b0); // R2 zero strobes
    issue(2'd1, 1, 8'hFF, 32'hA5A5_0F0F, 32'h0, 1'b0, 1'b0); // R9 timeout
    chk("R9 err held while idle", err, 1);
    issue(2'd0, 4, 8'h5A, 32'h0, 32'h0123_4567, 1'b1, 1'b0); // R9 err cleared by start
    issue(2'd1, 5, 8'h96, 32'hCAFE_F00D, 32'h0, 1'b1, 1'b1); // R11 start ignored while busy
    chk("R11 scoreboard drained", sbq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule